// File: doc/BRIEF.md
# DDR2 Precharge Spacing Guard

This block watches the command stream that a DDR2 SDRAM controller sends to the memory. For each bank it works out the earliest clock cycle at which a precharge may legally follow the reads, writes and precharges already sent to that bank. A scheduler reads the per-bank permission flags, and the all-bank flag, before it issues a precharge. A sticky violation flag records any precharge that was issued inside its forbidden window.

The timing values are elaboration-time parameters: additive latency, write latency, burst length, and the read-to-precharge and write-recovery times in picoseconds, together with the clock period in picoseconds. The picosecond values are turned into clock counts once, at elaboration, by rounding up. Each bank has one down-counter. A command that reaches a bank loads that counter with the new requirement only when the new requirement is longer than the time still left. Activate, refresh and data-path timing are handled elsewhere.

Top module: `pchg_spacing_guard`

## Requirements
- R1: While reset is asserted, and on release of reset, every per-bank flag and the all-bank flag read 1 and the violation flag reads 0.
- R2: Command code 0 (read) sent to bank b at cycle t clears bit b of `pre_ok_o` from cycle t+1 up to cycle t+G-1, and sets it again at cycle t+G. Here G = AL + BL/2 + max(ceil(tRTP/tCK), 2) - 2. The defaults give G = 2.
- R3: Command code 2 (write) sent to bank b at cycle t clears bit b from cycle t+1 up to cycle t+G-1, and sets it again at cycle t+G. Here G = WL + BL/2 + ceil(tWR/tCK). The defaults give G = 9.
- R4: Code 1 (read with auto-precharge) uses the same window as code 0. Code 3 (write with auto-precharge) uses the same window as code 2.
- R5: A command that targets one bank leaves the flags of every other bank unchanged.
- R6: `pre_all_ok_o` is 1 exactly when every bank's flag is 1. Code 5 (precharge all) issued while any bank's flag is 0 is a violation.
- R7: When a new command requires a shorter window than the one still pending on a bank, the pending window is kept. When it requires a longer window, the longer one replaces it.
- R8: Code 4 (precharge to one bank) issued while that bank's flag is 0 sets `viol_o` from the next cycle on. The flag then stays 1 until reset.
- R9: A precharge (code 4 or 5) issued while the banks it targets are all allowed does not set `viol_o`.
- R10: A cycle with `cmd_valid_i` low, or with code 6 or 7, changes no flag and sets no violation.
- R11: A precharge to a bank, or a precharge-all, needs only one clock of spacing before the next precharge. Back-to-back precharges on consecutive cycles keep the flags at 1 and raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_i | input | 3 | Command code: 0 read, 1 read+AP, 2 write, 3 write+AP, 4 precharge, 5 precharge all |
| bank_i | input | BANK_W | Target bank for codes 0 to 4 |
| pre_ok_o | output | NUM_BANKS | Per-bank flag: a precharge is allowed this cycle |
| pre_all_ok_o | output | 1 | A precharge-all is allowed this cycle |
| viol_o | output | 1 | Sticky flag: a precharge arrived too early |

## Verification
Single reads and writes are sent to separate banks and followed by idle cycles. This separates the two window lengths, and shows that a window ends on the exact cycle the formula gives. A write followed at once by a read on the same bank, and a read followed by a write, separate "keep the longer window" from "always reload". Precharges are then issued at the last forbidden cycle and at the first allowed cycle of a pending window, including a precharge-all while one bank is busy. This tells an off-by-one boundary apart from correct behaviour and shows that the violation flag is sticky across later legal traffic. Idle cycles, invalid codes and strobe-low commands are mixed in to show that they change nothing.

// File: rtl/pchg_guard_pkg.sv
package pchg_guard_pkg;

  typedef enum logic [2:0] {
    CMD_RD   = 3'd0,
    CMD_RDA  = 3'd1,
    CMD_WR   = 3'd2,
    CMD_WRA  = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5
  } cmd_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // read-to-precharge spacing in clocks
  function automatic int rd_gap(input int al, input int bl, input int trtp_ps, input int tck_ps);
    return al + bl / 2 + max_int(ceil_div(trtp_ps, tck_ps), 2) - 2;
  endfunction

  // write-recovery spacing in clocks
  function automatic int wr_gap(input int wl, input int bl, input int twr_ps, input int tck_ps);
    return wl + bl / 2 + ceil_div(twr_ps, tck_ps);
  endfunction

endpackage

// File: rtl/pchg_cmd_decode.sv
module pchg_cmd_decode
  import pchg_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 4,
  parameter logic [CNT_W-1:0] RD_LD = '0,
  parameter logic [CNT_W-1:0] WR_LD = '0,
  parameter logic [CNT_W-1:0] PP_LD = '0
) (
  input  logic                 valid_i,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] load_o,
  output logic [CNT_W-1:0]     load_val_o,
  output logic [NUM_BANKS-1:0] pre_hit_o
);

  logic one_bank;
  logic all_banks;
  logic is_pre;

  always_comb begin
    one_bank   = 1'b0;
    all_banks  = 1'b0;
    is_pre     = 1'b0;
    load_val_o = '0;
    if (valid_i) begin
      case (cmd_i)
        CMD_RD, CMD_RDA: begin
          one_bank   = 1'b1;
          load_val_o = RD_LD;
        end
        CMD_WR, CMD_WRA: begin
          one_bank   = 1'b1;
          load_val_o = WR_LD;
        end
        CMD_PRE: begin
          one_bank   = 1'b1;
          is_pre     = 1'b1;
          load_val_o = PP_LD;
        end
        CMD_PREA: begin
          all_banks  = 1'b1;
          is_pre     = 1'b1;
          load_val_o = PP_LD;
        end
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    logic sel;
    assign sel          = all_banks | (one_bank && (bank_i == BANK_W'(b)));
    assign load_o[b]    = sel;
    assign pre_hit_o[b] = sel & is_pre;
  end

endmodule

// File: rtl/pchg_bank_timer.sv
module pchg_bank_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             ok_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    // keep the longer of pending and new window
    cnt_d = (load_i && (load_val_i > dec)) ? load_val_i : dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ok_o = (cnt_q == '0);

endmodule

// File: rtl/pchg_viol_flag.sv
module pchg_viol_flag #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] pre_hit_i,
  input  logic [NUM_BANKS-1:0] ok_i,
  output logic                 viol_o
);

  logic viol_q;
  logic early;

  assign early = |(pre_hit_i & ~ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    viol_q <= 1'b0;
    else if (early) viol_q <= 1'b1;
  end

  assign viol_o = viol_q;

endmodule

// File: rtl/pchg_spacing_guard.sv
module pchg_spacing_guard
  import pchg_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int AL        = 0,
  parameter int WL        = 3,
  parameter int BL        = 4,
  parameter int T_RTP_PS  = 7500,
  parameter int T_WR_PS   = 15000,
  parameter int T_CK_PS   = 3750,
  parameter int PP_GAP    = 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic                 pre_all_ok_o,
  output logic                 viol_o
);

  localparam int RD_GAP  = rd_gap(AL, BL, T_RTP_PS, T_CK_PS);
  localparam int WR_GAP  = wr_gap(WL, BL, T_WR_PS, T_CK_PS);
  localparam int MAX_GAP = max_int(max_int(RD_GAP, WR_GAP), max_int(PP_GAP, 1));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'((RD_GAP > 0) ? RD_GAP - 1 : 0);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'((WR_GAP > 0) ? WR_GAP - 1 : 0);
  localparam logic [CNT_W-1:0] PP_LD = CNT_W'((PP_GAP > 0) ? PP_GAP - 1 : 0);

  logic [NUM_BANKS-1:0] load;
  logic [CNT_W-1:0]     load_val;
  logic [NUM_BANKS-1:0] pre_hit;
  logic [NUM_BANKS-1:0] ok;

  pchg_cmd_decode #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .CNT_W    (CNT_W),
    .RD_LD    (RD_LD),
    .WR_LD    (WR_LD),
    .PP_LD    (PP_LD)
  ) u_dec (
    .valid_i   (cmd_valid_i),
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .load_o    (load),
    .load_val_o(load_val),
    .pre_hit_o (pre_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pchg_bank_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[b]),
      .load_val_i(load_val),
      .ok_o      (ok[b])
    );
  end

  pchg_viol_flag #(.NUM_BANKS(NUM_BANKS)) u_viol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pre_hit_i(pre_hit),
    .ok_i     (ok),
    .viol_o   (viol_o)
  );

  assign pre_ok_o     = ok;
  assign pre_all_ok_o = &ok;

endmodule

// File: rtl/pchg_spacing_guard_chk.sv
module pchg_spacing_guard_chk
  import pchg_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int RD_GAP    = 2,
  parameter int WR_GAP    = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [NUM_BANKS-1:0] pre_ok_o,
  input logic                 pre_all_ok_o,
  input logic                 viol_o
);

  logic is_rd, is_wr, early_one, early_all;
  assign is_rd     = cmd_valid_i && (cmd_i == CMD_RD || cmd_i == CMD_RDA);
  assign is_wr     = cmd_valid_i && (cmd_i == CMD_WR || cmd_i == CMD_WRA);
  assign early_one = cmd_valid_i && (cmd_i == CMD_PRE) && !pre_ok_o[bank_i];
  assign early_all = cmd_valid_i && (cmd_i == CMD_PREA) && !pre_all_ok_o;

  AST_RD_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && RD_GAP > 1) |=> !pre_ok_o[$past(bank_i)]); // R2

  AST_WR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && WR_GAP > 1) |=> !pre_ok_o[$past(bank_i)]); // R3

  AST_EARLY_PRE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_one |=> viol_o); // R8

  AST_EARLY_PREALL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_all |=> viol_o); // R6

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o); // R8

  AST_NO_SPURIOUS_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!viol_o && !early_one && !early_all) |=> !viol_o); // R9

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hold
    AST_OK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pre_ok_o[b] && !((is_rd || is_wr) && bank_i == BANK_W'(b))) |=> pre_ok_o[b]); // R5
  end

endmodule

bind pchg_spacing_guard pchg_spacing_guard_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .RD_GAP   (RD_GAP),
  .WR_GAP   (WR_GAP)
) u_chk (.*);

// File: tb/pchg_spacing_guard_tb.sv
module pchg_spacing_guard_tb;

  localparam int NB       = 4;
  localparam int AL       = 0;
  localparam int WL       = 3;
  localparam int BL       = 4;
  localparam int T_RTP_PS = 7500;
  localparam int T_WR_PS  = 15000;
  localparam int T_CK_PS  = 3750;
  localparam int RTP_CK   = (T_RTP_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int WR_CK    = (T_WR_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int G_RD     = AL + BL / 2 + ((RTP_CK > 2) ? RTP_CK : 2) - 2;
  localparam int G_WR     = WL + BL / 2 + WR_CK;
  localparam int G_PP     = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [NB-1:0] pre_ok;
  logic       pre_all_ok;
  logic       viol;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [NB-1:0] ok;
    logic          all;
    logic          viol;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   rem[NB];
  logic exp_viol;

  always #4 clk = ~clk;

  pchg_spacing_guard #(
    .NUM_BANKS(NB), .AL(AL), .WL(WL), .BL(BL),
    .T_RTP_PS(T_RTP_PS), .T_WR_PS(T_WR_PS), .T_CK_PS(T_CK_PS), .PP_GAP(G_PP)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .bank_i      (bank),
    .pre_ok_o    (pre_ok),
    .pre_all_ok_o(pre_all_ok),
    .viol_o      (viol)
  );

  task automatic check(input bit ok_c, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok_c) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] model_ok();
    logic [NB-1:0] v;
    for (int k = 0; k < NB; k++) v[k] = (rem[k] == 0);
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NB; k++) rem[k] = 0;
    exp_viol = 1'b0;
  endtask

  // driver: one call per clock, pushes the expected post-edge state
  task automatic step(input bit v, input logic [2:0] c, input int b, input string tag);
    exp_t e;
    int   gap;
    @(negedge clk);
    cmd_valid = v;
    cmd       = c;
    bank      = 2'(b);
    if (v && c == 3'd4 && rem[b] != 0) exp_viol = 1'b1;
    if (v && c == 3'd5) for (int k = 0; k < NB; k++) if (rem[k] != 0) exp_viol = 1'b1;
    for (int k = 0; k < NB; k++) if (rem[k] > 0) rem[k]--;
    if (v && c <= 3'd5) begin
      gap = (c <= 3'd1) ? G_RD : (c <= 3'd3) ? G_WR : G_PP;
      for (int k = 0; k < NB; k++)
        if ((c == 3'd5) || (k == b)) if (gap - 1 > rem[k]) rem[k] = gap - 1;
    end
    e.ok   = model_ok();
    e.all  = &e.ok;
    e.viol = exp_viol;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 0, tag);
  endtask

  // monitor: compares after each edge
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(pre_ok == e.ok && pre_all_ok == e.all && viol == e.viol, e.tag,
            "ok/all/viol", {1'b0, pre_ok, pre_all_ok, viol}, {1'b0, e.ok, e.all, e.viol});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    model_reset();
    #1;
    check(pre_ok == '1 && pre_all_ok && !viol, "R1", "in reset",
          {3'b0, pre_ok, pre_all_ok}, {3'b0, 4'hf, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    idle(2, "R1");
    // R2: read window
    step(1'b1, 3'd0, 1, "R2");
    idle(3, "R2");
    // R3: write window, count cycles until allowed
    step(1'b1, 3'd2, 2, "R3");
    idle(G_WR + 1, "R3");
    // R4: auto-precharge variants
    step(1'b1, 3'd1, 0, "R4");
    step(1'b1, 3'd3, 3, "R4");
    idle(G_WR + 1, "R4");
    // R5 / R9: other bank unaffected, legal precharge there
    step(1'b1, 3'd2, 0, "R5");
    step(1'b1, 3'd4, 1, "R9");
    step(1'b1, 3'd0, 2, "R5");
    idle(G_WR, "R5");
    // R7: write then read keeps write window; read then write extends
    step(1'b1, 3'd2, 1, "R7");
    step(1'b1, 3'd0, 1, "R7");
    idle(3, "R7");
    step(1'b1, 3'd0, 3, "R7");
    step(1'b1, 3'd2, 3, "R7");
    idle(G_WR + 2, "R7");
    // R10: strobe low and unused codes
    step(1'b0, 3'd2, 0, "R10");
    step(1'b1, 3'd6, 1, "R10");
    step(1'b1, 3'd7, 2, "R10");
    step(1'b0, 3'd4, 0, "R10");
    // R11: back-to-back precharges
    step(1'b1, 3'd4, 2, "R11");
    step(1'b1, 3'd4, 2, "R11");
    step(1'b1, 3'd5, 0, "R11");
    step(1'b1, 3'd5, 0, "R11");
    // R8: precharge at the last forbidden cycle of a write window
    step(1'b1, 3'd2, 3, "R8");
    idle(G_WR - 2, "R8");
    step(1'b1, 3'd4, 3, "R8");
    idle(3, "R8");
    step(1'b1, 3'd4, 0, "R8");
    do_reset();
    idle(1, "R1");
    // R9: precharge at first allowed cycle
    step(1'b1, 3'd2, 1, "R9");
    idle(G_WR - 1, "R9");
    step(1'b1, 3'd4, 1, "R9");
    // R6: precharge-all while one bank is busy
    step(1'b1, 3'd0, 2, "R6");
    step(1'b1, 3'd5, 0, "R6");
    idle(2, "R6");
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R1", "queue drained", 8'(q.size()), 8'd0);
    finish_run();
  end

endmodule